// File: doc/BRIEF.md
# MDIO Management Master with Register Access

This block drives the two-wire management bus of Ethernet PHYs. Software programs a command word holding the PHY address, the PHY register number and the direction. For a write it also loads a 16-bit data word. It then writes the control register with the enable bit and the busy bit both set. The engine sends a clause-22 management frame on the MDC clock and MDIO data lines, and clears busy once the frame has ended. For a read, the 16 bits returned by the PHY land in the result register, where software fetches them after busy has dropped.

MDC is made from the system clock by a divider whose half-period is `DIV_N+1` system cycles. While the enable bit is clear, MDC stays low, the data line is released and start requests have no effect. Clearing enable while a frame is in flight abandons that frame.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset every register reads zero, MDC is low and MDIO is released (`mdio_oe` = 0).
- R2: The command register at byte offset 0x7E4 keeps bits 10:0 and reads back zeros above them. Bits 4:0 are the PHY register number, bits 9:5 the PHY address, and bit 10 set selects a read (clear selects a write).
- R3: While enabled, MDC is a square wave with a period of 2*(DIV_N+1) system clocks. It starts low.
- R4: A write frame is driven as 32 ones, then 01, opcode 01, the PHY address, the register number, turnaround 10 and the 16 data bits, all MSB first. Each bit is placed on MDIO at a falling edge of MDC.
- R5: A read frame carries opcode 10. The master drives only the 46 bits before the turnaround and releases MDIO from the turnaround to the end of the frame.
- R6: On a read, the master samples MDIO at each rising MDC edge during the 16 data bits. The word appears MSB first in bits 15:0 of the result register (offset 0x7EC) when busy clears.
- R7: A control-register (offset 0x7F0) write with bit 3 (enable) and bit 0 (busy) both set starts a frame. Bit 0 then reads 1 and returns to 0 at the MDC falling edge that follows the last frame bit, 65 falling edges after the start.
- R8: A start request written while busy is 1 is ignored. The frame in progress keeps its contents and its length.
- R9: While control bit 3 is clear, MDC is held low, MDIO is released, and a write of bit 0 alone does not set busy.
- R10: Clearing control bit 3 during a frame abandons it: busy reads 0, MDC is low and MDIO is released within three clocks.
- R11: The write-data register at offset 0x7E8 keeps bits 15:0 and reads back zeros above them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 12 | Byte offset for register writes and reads |
| bus_wen | input | 1 | Register write strobe, one cycle per write |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr`, combinational |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data driven by the master |
| mdio_oe | output | 1 | High while the master drives MDIO |
| mdio_i | input | 1 | Management data seen on the pin |

## Verification
The bench aims at frame framing and timing:
- It counts the MDC falling edges between start and completion. A design that drops or adds a bit shows a count other than 65.
- A design that samples one edge late returns a read word shifted by one bit. The 0x8001 pattern exposes this at both ends.
- A design that turns the line around at the wrong bit shows a count of driven read-frame bits other than 46.

It also repeats a start request in the middle of a frame. A design that restarts the frame emits extra edges and the wrong opcode. It drops enable mid-frame too, where a design that ignores this keeps busy set and MDC running. A behavioural model compares MDC, MDIO and the register readback on every clock.

// File: rtl/mdio_mgmt_pkg.sv
// Shared constants, command type and frame builder for the MDIO management master.
package mdio_mgmt_pkg;

    localparam int REG_AW = 12;
    localparam logic [REG_AW-1:0] OFS_CMD   = 12'h7E4;
    localparam logic [REG_AW-1:0] OFS_WDATA = 12'h7E8;
    localparam logic [REG_AW-1:0] OFS_RDATA = 12'h7EC;
    localparam logic [REG_AW-1:0] OFS_CTRL  = 12'h7F0;

    localparam int CTRL_BUSY_BIT = 0;
    localparam int CTRL_EN_BIT   = 3;

    localparam int FIELD_W    = 5;
    localparam int DATA_W     = 16;
    localparam int PRE_BITS   = 32;
    localparam int FRAME_BITS = PRE_BITS + 2 + 2 + 2 * FIELD_W + 2 + DATA_W;
    localparam int TA_FIRST   = FRAME_BITS - DATA_W - 2;
    localparam int DATA_FIRST = FRAME_BITS - DATA_W;
    localparam int IDX_W      = $clog2(FRAME_BITS + 1);
    localparam int CMD_W      = 2 * FIELD_W + 1;

    // Command register layout: direction on top, then PHY address, then register number.
    typedef struct packed {
        logic               rd;
        logic [FIELD_W-1:0] phy;
        logic [FIELD_W-1:0] regad;
    } mgmt_cmd_t;

    // Builds the complete clause-22 frame, first bit on the left.
    function automatic logic [FRAME_BITS-1:0] build_frame(mgmt_cmd_t c, logic [DATA_W-1:0] d);
        logic [1:0] op;
        logic [DATA_W-1:0] payload;
        op      = c.rd ? 2'b10 : 2'b01;
        payload = c.rd ? '0 : d;
        return {{PRE_BITS{1'b1}}, 2'b01, op, c.phy, c.regad, 2'b10, payload};
    endfunction

endpackage

// File: rtl/mdio_clk_div.sv
// MDC generator. Toggles MDC every DIV_N+1 system clocks while enabled.
// It flags the cycle just before each rising and falling MDC edge.
// Assumes en is a registered level; MDC restarts low whenever en drops.
module mdio_clk_div #(
    parameter int DIV_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic mdc,
    output logic tick_rise,
    output logic tick_fall
);
    localparam int CW = (DIV_N < 1) ? 1 : $clog2(DIV_N + 1);
    localparam logic [CW-1:0] LIMIT = CW'(DIV_N);

    logic [CW-1:0] cnt_q;
    logic          wrap;

    assign wrap      = en && (cnt_q == LIMIT);
    assign tick_rise = wrap && !mdc;
    assign tick_fall = wrap && mdc;

    // Half-period counter and MDC toggle, held at zero while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            mdc   <= ~mdc;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_frame_engine.sv
// Frame engine. It loads a frame on start and shifts one bit out on each falling MDC tick.
// On reads it releases MDIO from the turnaround on and samples data on rising ticks.
// The frame finishes on the falling tick after the last bit.
// Assumes start is only raised while not busy; a drop of en abandons the frame.
module mdio_frame_engine
    import mdio_mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              start,
    input  mgmt_cmd_t         cmd,
    input  logic [DATA_W-1:0] wdata,
    input  logic              tick_rise,
    input  logic              tick_fall,
    input  logic              mdio_i,
    output logic              busy,
    output logic [DATA_W-1:0] rd_result,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic [IDX_W-1:0]  bit_idx,
    output logic              is_read
);
    logic [FRAME_BITS-1:0] frame_q;
    logic [DATA_W-1:0]     shift_q;
    logic                  last_done;

    assign last_done = busy && tick_fall && (bit_idx == IDX_W'(FRAME_BITS));

    // Sequencing: load on start, emit one bit per falling tick, stop after the last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            bit_idx <= '0;
            frame_q <= '0;
            is_read <= 1'b0;
            mdio_o  <= 1'b0;
            mdio_oe <= 1'b0;
        end else if (start) begin
            busy    <= 1'b1;
            bit_idx <= '0;
            frame_q <= build_frame(cmd, wdata);
            is_read <= cmd.rd;
        end else if (!en) begin
            busy    <= 1'b0;
            mdio_oe <= 1'b0;
        end else if (last_done) begin
            busy    <= 1'b0;
            mdio_oe <= 1'b0;
        end else if (busy && tick_fall) begin
            mdio_o  <= frame_q[FRAME_BITS-1];
            mdio_oe <= !(is_read && (bit_idx >= IDX_W'(TA_FIRST)));
            frame_q <= {frame_q[FRAME_BITS-2:0], 1'b0};
            bit_idx <= bit_idx + 1'b1;
        end
    end

    // Read data capture on rising ticks while a data bit is on the line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q <= '0;
        end else if (en && busy && is_read && tick_rise && (bit_idx > IDX_W'(DATA_FIRST))) begin
            shift_q <= {shift_q[DATA_W-2:0], mdio_i};
        end
    end

    // Result register, updated only when a read frame completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_result <= '0;
        end else if (en && !start && last_done && is_read) begin
            rd_result <= shift_q;
        end
    end
endmodule

// File: rtl/mdio_csr.sv
// Register file. Holds the command, write data and enable.
// It raises the start strobe and multiplexes read data.
// Assumes one write per strobe cycle; reads are combinational on the offset.
module mdio_csr
    import mdio_mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic              bus_wen,
    input  logic [31:0]       bus_wdata,
    input  logic              busy,
    input  logic [DATA_W-1:0] rd_result,
    output logic [31:0]       bus_rdata,
    output logic              enable,
    output logic              start,
    output mgmt_cmd_t         cmd,
    output logic [DATA_W-1:0] wdata
);
    logic ctrl_wr;

    assign ctrl_wr = bus_wen && (bus_addr == OFS_CTRL);
    assign start   = ctrl_wr && bus_wdata[CTRL_EN_BIT] && bus_wdata[CTRL_BUSY_BIT] && !busy;

    // Software-written registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd    <= '0;
            wdata  <= '0;
            enable <= 1'b0;
        end else if (bus_wen) begin
            if (bus_addr == OFS_CMD)   cmd    <= bus_wdata[CMD_W-1:0];
            if (bus_addr == OFS_WDATA) wdata  <= bus_wdata[DATA_W-1:0];
            if (ctrl_wr)               enable <= bus_wdata[CTRL_EN_BIT];
        end
    end

    // Read multiplexer.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_CMD:   bus_rdata[CMD_W-1:0]  = cmd;
            OFS_WDATA: bus_rdata[DATA_W-1:0] = wdata;
            OFS_RDATA: bus_rdata[DATA_W-1:0] = rd_result;
            OFS_CTRL: begin
                bus_rdata[CTRL_EN_BIT]   = enable;
                bus_rdata[CTRL_BUSY_BIT] = busy;
            end
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/mdio_mgmt_master.sv
// Top of the MDIO management master. Joins the register file, the MDC divider and the frame engine.
// Assumes an external tristate buffer built from mdio_o / mdio_oe and a pull-up on MDIO.
module mdio_mgmt_master
    import mdio_mgmt_pkg::*;
#(
    parameter int DIV_N = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [11:0] bus_addr,
    input  logic        bus_wen,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic              enable;
    logic              start;
    logic              busy;
    logic              tick_rise;
    logic              tick_fall;
    logic              is_read;
    logic [IDX_W-1:0]  bit_idx;
    logic [DATA_W-1:0] rd_result;
    logic [DATA_W-1:0] wdata;
    mgmt_cmd_t         cmd;

    mdio_csr u_csr (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
        .bus_wdata(bus_wdata), .busy(busy), .rd_result(rd_result),
        .bus_rdata(bus_rdata), .enable(enable), .start(start), .cmd(cmd), .wdata(wdata)
    );

    mdio_clk_div #(.DIV_N(DIV_N)) u_div (
        .clk(clk), .rst_n(rst_n), .en(enable), .mdc(mdc),
        .tick_rise(tick_rise), .tick_fall(tick_fall)
    );

    mdio_frame_engine u_eng (
        .clk(clk), .rst_n(rst_n), .en(enable), .start(start), .cmd(cmd), .wdata(wdata),
        .tick_rise(tick_rise), .tick_fall(tick_fall), .mdio_i(mdio_i),
        .busy(busy), .rd_result(rd_result), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .bit_idx(bit_idx), .is_read(is_read)
    );
endmodule

// File: rtl/mdio_mgmt_checker.sv
// Protocol checker for the MDIO management master, bound to its top.
module mdio_mgmt_checker
    import mdio_mgmt_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [11:0]       bus_addr,
    input logic              bus_wen,
    input logic [31:0]       bus_wdata,
    input logic              enable,
    input logic              busy,
    input logic              mdc,
    input logic              mdio_o,
    input logic              mdio_oe,
    input logic [IDX_W-1:0]  bit_idx,
    input logic              is_read
);
    // R9
    mdc_held_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !mdc);

    // R9
    mdio_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !mdio_oe);

    // R7
    busy_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(bus_wen && (bus_addr == OFS_CTRL) &&
                              bus_wdata[CTRL_EN_BIT] && bus_wdata[CTRL_BUSY_BIT]));

    // R4
    mdio_moves_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_oe && $past(mdio_oe) && !$stable(mdio_o)) |-> $fell(mdc));

    // R5
    read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && is_read && (bit_idx > IDX_W'(TA_FIRST))) |-> !mdio_oe);

    // R8
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (bit_idx >= $past(bit_idx)));
endmodule

bind mdio_mgmt_master mdio_mgmt_checker u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen), .bus_wdata(bus_wdata),
    .enable(enable), .busy(busy), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .bit_idx(bit_idx), .is_read(is_read)
);

// File: tb/tb_mdio_mgmt_master.sv
module tb_mdio_mgmt_master;
    localparam int N = 2;
    localparam logic [11:0] A_CMD = 12'h7E4, A_WD = 12'h7E8, A_RD = 12'h7EC, A_CTRL = 12'h7F0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [11:0] bus_addr = A_CTRL;
    logic bus_wen = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic mdc, mdio_o, mdio_oe;
    logic mdio_i = 1'b1;

    int total = 0, fails = 0, cycles = 0;
    bit done = 0;

    mdio_mgmt_master #(.DIV_N(N)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc), .mdio_o(mdio_o),
        .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    always #10 clk = ~clk;

    // ---------------- behavioural reference model ----------------
    bit m_en, m_busy, m_mdc, m_rd, m_oe, m_o;
    int m_div, m_idx;
    bit [10:0] m_cmd;
    bit [15:0] m_wd, m_res, m_shift, phy_pat;
    bit [63:0] m_frame;

    function automatic bit [63:0] exp_frame(bit rd, bit [4:0] phy, bit [4:0] rg, bit [15:0] d);
        return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, rg, 2'b10, (rd ? 16'h0 : d)};
    endfunction

    always @(posedge clk) begin
        bit fall, rise, st, old_en;
        if (!rst_n) begin
            m_en = 0; m_busy = 0; m_mdc = 0; m_rd = 0; m_oe = 0; m_o = 0;
            m_div = 0; m_idx = 0; m_cmd = 0; m_wd = 0; m_res = 0; m_shift = 0; m_frame = 0;
        end else begin
            old_en = m_en;
            fall = m_en && m_div == N && m_mdc;
            rise = m_en && m_div == N && !m_mdc;
            st = bus_wen && bus_addr == A_CTRL && bus_wdata[3] && bus_wdata[0] && !m_busy;
            if (!m_en) begin m_div = 0; m_mdc = 0; end
            else if (m_div == N) begin m_div = 0; m_mdc = !m_mdc; end
            else m_div++;
            if (st) begin
                m_busy = 1; m_idx = 0; m_rd = m_cmd[10];
                m_frame = exp_frame(m_cmd[10], m_cmd[9:5], m_cmd[4:0], m_wd);
            end else if (!old_en) begin
                m_busy = 0; m_oe = 0;
            end else if (m_busy) begin
                if (fall) begin
                    if (m_idx == 64) begin
                        m_busy = 0; m_oe = 0;
                        if (m_rd) m_res = m_shift;
                    end else begin
                        m_o = m_frame[63 - m_idx];
                        m_oe = !(m_rd && m_idx >= 46);
                        m_idx++;
                    end
                end
                if (rise && m_rd && m_idx >= 49) m_shift = {m_shift[14:0], mdio_i};
            end
            if (bus_wen && bus_addr == A_CMD) m_cmd = bus_wdata[10:0];
            if (bus_wen && bus_addr == A_WD) m_wd = bus_wdata[15:0];
            if (bus_wen && bus_addr == A_CTRL) m_en = bus_wdata[3];
        end
    end

    // PHY model: puts the read pattern on the line, MSB first, during the data bits.
    always @(negedge clk)
        mdio_i <= (m_busy && m_rd && m_idx >= 49 && m_idx <= 64) ? phy_pat[64 - m_idx] : 1'b1;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic bit [31:0] exp_rdata(bit [11:0] a);
        case (a)
            A_CMD:  return {21'b0, m_cmd};
            A_WD:   return {16'b0, m_wd};
            A_RD:   return {16'b0, m_res};
            A_CTRL: return {28'b0, m_en, 2'b0, m_busy};
            default: return 32'h0;
        endcase
    endfunction

    // ---------------- per-clock comparison and frame observation ----------------
    bit prev_mdc, prev_busy;
    int falls, drv_bits, last_rise, period;
    logic [63:0] col;

    always @(posedge clk) begin
        #5;
        if (rst_n) begin
            chk("R3 mdc vs model", 32'(mdc), 32'(m_mdc));
            chk("R5 mdio_oe vs model", 32'(mdio_oe), 32'(m_oe));
            if (mdio_oe) chk("R4 mdio_o vs model", 32'(mdio_o), 32'(m_o));
            chk("R2 register readback vs model", bus_rdata, exp_rdata(bus_addr));
            if (prev_mdc && !mdc && prev_busy) begin
                falls++;
                if (mdio_oe) begin col = {col[62:0], mdio_o}; drv_bits++; end
            end
            if (!prev_mdc && mdc) begin period = cycles - last_rise; last_rise = cycles; end
        end
        prev_mdc = mdc;
        prev_busy = m_busy;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            fails++; total++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
        @(negedge clk);
        bus_wen = 1'b0; bus_addr = A_CTRL;
    endtask

    task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
        bus_addr = A_CTRL;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (bus_rdata[0]) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic arm();
        falls = 0; drv_bits = 0; col = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        rd_chk("R1 cmd after reset", A_CMD, 0);
        rd_chk("R1 wdata after reset", A_WD, 0);
        rd_chk("R1 result after reset", A_RD, 0);
        rd_chk("R1 ctrl after reset", A_CTRL, 0);
        chk("R1 mdc low after reset", 32'(mdc), 0);
        chk("R1 mdio released after reset", 32'(mdio_oe), 0);

        // R2: field layout and width of the command register
        wr(A_CMD, 32'hFFFF_F800 | (32'h13 << 5) | 32'h0A);
        rd_chk("R2 cmd keeps bits 10:0", A_CMD, (32'h13 << 5) | 32'h0A);
        // R11: write data register width
        wr(A_WD, 32'hBEEF_A5C3);
        rd_chk("R11 wdata keeps bits 15:0", A_WD, 32'h0000_A5C3);

        // R9: start without enable is ignored, MDC stays low
        wr(A_CTRL, 32'h1);
        repeat (30) @(negedge clk);
        rd_chk("R9 no busy without enable", A_CTRL, 0);
        chk("R9 mdc low while disabled", 32'(mdc), 0);
        chk("R9 mdio released while disabled", 32'(mdio_oe), 0);

        // R3: MDC period
        wr(A_CTRL, 32'h8);
        repeat (40) @(negedge clk);
        chk("R3 mdc period", 32'(period), 32'(2 * (N + 1)));

        // R4, R7, R8: write frame with a start request repeated mid-frame
        arm();
        wr(A_CTRL, 32'h9);
        rd_chk("R7 busy set after start", A_CTRL, 32'h9);
        repeat (100) @(negedge clk);
        wr(A_CMD, 32'h400 | (32'h1F << 5));
        wr(A_CTRL, 32'h9);
        wait_idle();
        chk("R7 falling edges per frame", 32'(falls), 65);
        chk("R4 write frame bits", col[31:0], exp_frame(0, 5'h13, 5'h0A, 16'hA5C3) >> 0);
        chk("R4 write frame preamble", col[63:32], 32'hFFFF_FFFF);
        chk("R8 driven bits of write frame", 32'(drv_bits), 64);

        // R5, R6: read frame from PHY 0x1F register 0
        phy_pat = 16'h5AC3;
        arm();
        wr(A_CTRL, 32'h9);
        wait_idle();
        chk("R5 driven bits of read frame", 32'(drv_bits), 46);
        chk("R5 read header bits", col[45:0], 46'(exp_frame(1, 5'h1F, 5'h00, 0) >> 18));
        rd_chk("R6 read result 5AC3", A_RD, 32'h5AC3);
        chk("R7 falling edges read frame", 32'(falls), 65);

        // R6: boundary pattern with both end bits set
        phy_pat = 16'h8001;
        wr(A_CMD, 32'h400 | (32'h01 << 5) | 32'h1F);
        wr(A_CTRL, 32'h9);
        wait_idle();
        rd_chk("R6 read result 8001", A_RD, 32'h8001);

        // R10: abandon a frame by clearing enable
        wr(A_CTRL, 32'h9);
        repeat (60) @(negedge clk);
        wr(A_CTRL, 32'h0);
        repeat (2) @(negedge clk);
        rd_chk("R10 busy cleared on disable", A_CTRL, 0);
        chk("R10 mdc low on disable", 32'(mdc), 0);
        chk("R10 mdio released on disable", 32'(mdio_oe), 0);
        rd_chk("R10 result unchanged by aborted frame", A_RD, 32'h8001);

        repeat (5) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule